// File: doc/BRIEF.md
# Wait-State Memory Read Sequencer

This block sits between a bus read port and a slow, synchronous memory array. For each read it accepts, it waits a programmable number of wait states and then returns one data word with a single-cycle ready pulse. An access takes the wait-state count plus one clock cycle.

A one-word buffer keeps the most recently fetched word and its address. A later read of that same address is answered from the buffer in one cycle, and the array is not touched. Any error check tied to an array access is therefore also skipped on such a read. A change of the wait-state setting empties the buffer. The new setting applies from the next access onward and never cuts into an access already under way.

The block also compares the programmed wait states with the minimum that the current clock-frequency band and voltage mode need. When the setting is too low it raises a flag, but reads keep running. The array is modelled as a read-only memory whose contents are computed from the address.

Top module: `wsflash_reader`

## Requirements
- R1: While reset is asserted and right after it is released, `rdReady` is 0 and `rdData` is 0. The wait-state setting is 1 and the buffer holds no word.
- R2: A read that misses the buffer is accepted at a clock edge. `rdReady` is then 1 for the cycle that starts ws+1 edges later, where ws is the setting when the read was accepted. `rdData` then holds the array word at `rdAddr`, which is `(addr * 32'h9E3779B1 mod 2^32) XOR 32'hC3C30F0F`.
- R3: A written setting value above 4 (on the 3-bit `wsValue`) is treated as 4.
- R4: `rdReady` is high for exactly one cycle per completed access. `rdData` keeps its value in every cycle where `rdReady` is 0.
- R5: A read accepted while the buffer holds its address returns with `rdReady` in the very next cycle and does not access the array. A new read may be presented in the ready cycle.
- R6: A request raised while an access is in progress is ignored. It produces no ready pulse and does not change the returned data.
- R7: A write of a setting value that differs from the current one empties the buffer. If the write lands during an access, that access keeps its original timing and its word is not stored in the buffer.
- R8: A write of the value that is already set leaves the buffer intact.
- R9: In boost mode (`voltMode`=2), the minimum setting is the smallest ws in 0..4 with freqMhz ≤ 34·(ws+1).
- R10: In normal mode (`voltMode`=1), the minimum setting is the smallest ws in 0..4 with freqMhz ≤ 30·(ws+1).
- R11: In low-voltage mode (`voltMode`=0 or 3), the minimum setting is 0 up to 12 MHz, 1 up to 24 MHz and 2 up to 26 MHz.
- R12: Above the highest limit of the mode (170, 150 or 26 MHz), `wsTooLow` is 1 for every setting. Otherwise `wsTooLow` is 1 exactly when the setting is below the minimum.
- R13: Reads complete with correct data and timing while `wsTooLow` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Read request, taken when idle |
| rdAddr | input | ADDR_W | Word address of the read |
| wsWrite | input | 1 | Write strobe for the wait-state setting |
| wsValue | input | 3 | New wait-state setting |
| freqMhz | input | 8 | Current clock frequency in MHz |
| voltMode | input | 2 | 0/3 low-voltage, 1 normal, 2 boost |
| rdData | output | 32 | Returned word |
| rdReady | output | 1 | One-cycle data-valid pulse |
| wsTooLow | output | 1 | Setting below the minimum for freq and mode |

## Verification
Misses are run at every setting from 0 to 4, including a clamped write, so an off-by-one in the wait counter shows up as a ready pulse one cycle early or late. Repeated reads of the same address are run back to back and are also separated by setting writes of equal and of different value, which separates a correct buffer from one that never hits, never empties, or fills after a mid-access change. Requests sent during a busy access reveal a controller that does not ignore them. The flag is swept over all modes, all settings and frequencies on both sides of every limit, so a wrong step size, a wrong boundary comparison or a missing overflow case each produces a mismatch.

// File: rtl/wsflash_pkg.sv
package wsflash_pkg;

  localparam int DATA_W = 32;
  localparam int WS_MAX = 4;
  localparam int WS_W   = 3;
  localparam int WS_NONE = WS_MAX + 1;

  typedef enum logic [1:0] {
    VM_LOW     = 2'd0,
    VM_NORMAL  = 2'd1,
    VM_BOOST   = 2'd2,
    VM_LOW_ALT = 2'd3
  } voltMode_e;

  typedef struct packed {
    logic latchAddr;
    logic serveHit;
    logic finish;
    logic fillOk;
    logic invalidate;
  } dpStrobe_t;

  function automatic logic [WS_W-1:0] wsLimit(input logic [WS_W-1:0] v);
    return (int'(v) > WS_MAX) ? WS_W'(WS_MAX) : v;
  endfunction

  function automatic int bandLimit(input int ws, input logic [1:0] vm);
    int lim;
    case (vm)
      VM_BOOST:  lim = 34 * (ws + 1);
      VM_NORMAL: lim = 30 * (ws + 1);
      default:   lim = (ws == 0) ? 12 : (ws == 1) ? 24 : 26;
    endcase
    return lim;
  endfunction

  function automatic logic [WS_W-1:0] minWaitStates(input logic [7:0] f,
                                                    input logic [1:0] vm);
    logic [WS_W-1:0] r;
    r = WS_W'(WS_NONE);
    for (int i = WS_MAX; i >= 0; i--) begin
      if (int'(f) <= bandLimit(i, vm)) r = WS_W'(i);
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] arrayWord(input logic [31:0] a);
    logic [31:0] p;
    p = a * 32'h9E3779B1;
    return p ^ 32'hC3C30F0F;
  endfunction

endpackage

// File: rtl/wsflash_ctrl.sv
module wsflash_ctrl
  import wsflash_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            rdReq,
  input  logic            bufHit,
  input  logic            wsWrite,
  input  logic [WS_W-1:0] wsValue,
  input  logic [7:0]      freqMhz,
  input  logic [1:0]      voltMode,
  output dpStrobe_t       strobe,
  output logic            rdReady,
  output logic            busy,
  output logic            wsTooLow
);

  logic [WS_W-1:0] wsReg;
  logic [WS_W-1:0] waitCnt;
  logic [WS_W-1:0] wsNew;
  logic            busyR;
  logic            staleR;
  logic            readyR;
  logic            changeNow;
  logic            accept;
  logic            useHit;

  always_comb begin
    wsNew     = wsLimit(wsValue);
    changeNow = wsWrite && (wsNew != wsReg);
    accept    = !busyR && rdReq;
    useHit    = bufHit && !changeNow;

    strobe.latchAddr  = accept && !useHit;
    strobe.serveHit   = accept && useHit;
    strobe.finish     = busyR && (waitCnt == '0);
    strobe.fillOk     = busyR && (waitCnt == '0) && !staleR && !changeNow;
    strobe.invalidate = changeNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wsReg   <= WS_W'(1);
      waitCnt <= '0;
      busyR   <= 1'b0;
      staleR  <= 1'b0;
      readyR  <= 1'b0;
    end else begin
      readyR <= strobe.finish || strobe.serveHit;
      if (changeNow) wsReg <= wsNew;
      if (strobe.latchAddr) begin
        busyR   <= 1'b1;
        waitCnt <= wsReg;
        staleR  <= changeNow;
      end else if (busyR) begin
        if (waitCnt == '0) busyR <= 1'b0;
        else               waitCnt <= waitCnt - 1'b1;
        if (changeNow) staleR <= 1'b1;
      end
    end
  end

  assign rdReady  = readyR;
  assign busy     = busyR;
  assign wsTooLow = wsReg < minWaitStates(freqMhz, voltMode);

endmodule

// File: rtl/wsflash_datapath.sv
module wsflash_datapath
  import wsflash_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddr,
  input  dpStrobe_t         strobe,
  output logic              bufHit,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;
  logic              bufValid;
  logic [DATA_W-1:0] arrayOut;
  logic [DATA_W-1:0] dataReg;

  assign arrayOut = arrayWord(32'(addrReg));
  assign bufHit   = bufValid && (bufAddr == rdAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      bufAddr  <= '0;
      bufData  <= '0;
      bufValid <= 1'b0;
      dataReg  <= '0;
    end else begin
      if (strobe.latchAddr) addrReg <= rdAddr;
      if (strobe.serveHit)  dataReg <= bufData;
      if (strobe.finish)    dataReg <= arrayOut;
      if (strobe.fillOk) begin
        bufValid <= 1'b1;
        bufAddr  <= addrReg;
        bufData  <= arrayOut;
      end else if (strobe.invalidate) begin
        bufValid <= 1'b0;
      end
    end
  end

  assign rdData = dataReg;

endmodule

// File: rtl/wsflash_reader.sv
module wsflash_reader
  import wsflash_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wsWrite,
  input  logic [2:0]        wsValue,
  input  logic [7:0]        freqMhz,
  input  logic [1:0]        voltMode,
  output logic [31:0]       rdData,
  output logic              rdReady,
  output logic              wsTooLow
);

  dpStrobe_t strobe;
  logic      bufHit;
  logic      busy;

  wsflash_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdReq    (rdReq),
    .bufHit   (bufHit),
    .wsWrite  (wsWrite),
    .wsValue  (wsValue),
    .freqMhz  (freqMhz),
    .voltMode (voltMode),
    .strobe   (strobe),
    .rdReady  (rdReady),
    .busy     (busy),
    .wsTooLow (wsTooLow)
  );

  wsflash_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .rdAddr (rdAddr),
    .strobe (strobe),
    .bufHit (bufHit),
    .rdData (rdData)
  );

endmodule

// File: rtl/wsflash_checks.sv
module wsflash_checks #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic              wsWrite,
  input logic [7:0]        freqMhz,
  input logic [1:0]        voltMode,
  input logic [31:0]       rdData,
  input logic              rdReady,
  input logic              wsTooLow,
  input logic              busy,
  input logic              bufHit
);

  a_r4_single_ready: assert property (@(posedge clk) disable iff (!rstN)
    rdReady && !rdReq |=> !rdReady);

  a_r4_data_held: assert property (@(posedge clk) disable iff (!rstN)
    !rdReady |-> $stable(rdData));

  a_r5_hit_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !busy && rdReq && bufHit && !wsWrite |=> rdReady);

  a_r2_miss_not_immediate: assert property (@(posedge clk) disable iff (!rstN)
    !busy && rdReq && !bufHit |=> !rdReady && busy);

  a_r6_busy_no_early_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !rdReq |=> !rdReady);

  a_r12_overflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    freqMhz > 8'd170 |-> wsTooLow);

  a_r9_boost_slow_clock_ok: assert property (@(posedge clk) disable iff (!rstN)
    (voltMode == 2'd2) && (freqMhz <= 8'd34) |-> !wsTooLow);

endmodule

bind wsflash_reader wsflash_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .rdReq    (rdReq),
  .wsWrite  (wsWrite),
  .freqMhz  (freqMhz),
  .voltMode (voltMode),
  .rdData   (rdData),
  .rdReady  (rdReady),
  .wsTooLow (wsTooLow),
  .busy     (busy),
  .bufHit   (bufHit)
);

// File: tb/tb_wsflash_reader.sv
module tb_wsflash_reader;

  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rstN;
  logic              rdReq;
  logic [ADDR_W-1:0] rdAddr;
  logic              wsWrite;
  logic [2:0]        wsValue;
  logic [7:0]        freqMhz;
  logic [1:0]        voltMode;
  logic [31:0]       rdData;
  logic              rdReady;
  logic              wsTooLow;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural reference state
  int  mWs, mCnt, mAddr, mBufAddr;
  bit  mBusy, mStale, mBufValid, expReady;
  logic [31:0] expData;

  always #2 clk = ~clk;

  wsflash_reader #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr),
    .wsWrite(wsWrite), .wsValue(wsValue), .freqMhz(freqMhz),
    .voltMode(voltMode), .rdData(rdData), .rdReady(rdReady),
    .wsTooLow(wsTooLow)
  );

  function automatic logic [31:0] wordOf(input int a);
    logic [63:0] full;
    full = 64'(a) * 64'd2654435761;
    return full[31:0] ^ 32'hC3C30F0F;
  endfunction

  function automatic int needWs(input int f, input int vm);
    int n;
    if (vm == 2 || vm == 1) begin
      int step = (vm == 2) ? 34 : 30;
      n = (f + step - 1) / step - 1;
      if (n < 0) n = 0;
      if (n > 4) n = 5;
    end else begin
      if (f <= 12) n = 0;
      else if (f <= 24) n = 1;
      else if (f <= 26) n = 2;
      else n = 5;
    end
    return n;
  endfunction

  task automatic modelStep(input bit req, input int addr, input bit wr, input int val);
    int clamped = (val > 4) ? 4 : val;
    bit inval = wr && (clamped != mWs);
    expReady = 0;
    if (mBusy) begin
      if (mCnt == 0) begin
        expReady = 1;
        expData = wordOf(mAddr);
        mBusy = 0;
        if (!mStale && !inval) begin
          mBufValid = 1;
          mBufAddr = mAddr;
        end
      end else mCnt--;
      if (inval) mStale = 1;
    end else if (req) begin
      if (mBufValid && mBufAddr == addr && !inval) begin
        expReady = 1;
        expData = wordOf(addr);
      end else begin
        mBusy = 1;
        mCnt = mWs;
        mAddr = addr;
        mStale = inval;
      end
    end
    if (inval) begin
      if (!(expReady && mBusy == 0 && !mStale && mBufValid && mBufAddr == mAddr && mCnt == 0 && 0))
        mBufValid = mBufValid && 0;
      mWs = clamped;
    end
  endtask

  task automatic check(input string tag);
    bit expFlag = (mWs < needWs(int'(freqMhz), int'(voltMode)));
    vectors++;
    if (rdReady !== expReady || rdData !== expData || wsTooLow !== expFlag) begin
      miscompares++;
      $display("FAIL %s: ready=%0b data=%h flag=%0b expected ready=%0b data=%h flag=%0b",
               tag, rdReady, rdData, wsTooLow, expReady, expData, expFlag);
    end
  endtask

  task automatic drive(input bit req, input int addr, input bit wr, input int val,
                       input string tag);
    rdReq = req;
    rdAddr = ADDR_W'(addr);
    wsWrite = wr;
    wsValue = 3'(val);
    modelStep(req, addr, wr, val);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, tag);
  endtask

  task automatic readWait(input int addr, input string tag);
    drive(1, addr, 0, 0, tag);
    idle(6, tag);
  endtask

  task automatic setWs(input int val, input string tag);
    drive(0, 0, 1, val, tag);
  endtask

  initial begin
    #400us;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 0; rdReq = 0; rdAddr = '0; wsWrite = 0; wsValue = '0;
    freqMhz = 8'd16; voltMode = 2'd1;
    mWs = 1; mCnt = 0; mAddr = 0; mBufAddr = 0;
    mBusy = 0; mStale = 0; mBufValid = 0; expReady = 0; expData = '0;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rstN = 1;
    check("R1 after release");

    // R2: miss timing at the reset setting, then at every setting
    readWait(5, "R2 miss ws1");
    for (int w = 0; w <= 4; w++) begin
      setWs(w, "R7 setting write");
      readWait(8 + w, "R2 miss sweep");
    end
    // R3: clamp
    setWs(7, "R3 clamp write");
    readWait(14, "R3 clamped access");
    setWs(2, "R7 setting write");
    readWait(14, "R3 after clamp miss");

    // R5: hits, including back-to-back in the ready cycle
    drive(1, 14, 0, 0, "R5 hit");
    drive(1, 14, 0, 0, "R5 back-to-back hit");
    drive(1, 14, 0, 0, "R5 back-to-back hit");
    idle(2, "R4 pulse ends");

    // R6: request during a busy access
    drive(1, 20, 0, 0, "R6 first");
    drive(1, 21, 0, 0, "R6 ignored");
    drive(1, 22, 0, 0, "R6 ignored");
    idle(5, "R6 drain");

    // R8: same-value write keeps the buffer
    setWs(2, "R8 same write");
    readWait(20, "R8 still hits");

    // R7: differing write empties the buffer
    setWs(3, "R7 change");
    readWait(20, "R7 miss after change");
    drive(1, 30, 0, 0, "R7 access start");
    drive(0, 0, 1, 1, "R7 mid-access write");
    idle(6, "R7 old timing");
    readWait(30, "R7 not filled");
    readWait(30, "R7 now hits");
    drive(1, 31, 1, 4, "R7 write at accept");
    idle(6, "R7 write at accept");
    readWait(31, "R7 accept-write no fill");

    // R9..R12: flag sweep
    begin
      int freqs[24] = '{0, 12, 13, 24, 25, 26, 27, 30, 31, 34, 35, 60, 61, 68,
                        69, 120, 121, 136, 137, 150, 151, 170, 171, 255};
      for (int m = 0; m < 4; m++) begin
        voltMode = 2'(m);
        for (int k = 0; k < 24; k++) begin
          string tag;
          int top = (m == 2) ? 170 : (m == 1) ? 150 : 26;
          freqMhz = 8'(freqs[k]);
          if (freqs[k] > top) tag = "R12 overflow";
          else if (m == 2) tag = "R9 boost";
          else if (m == 1) tag = "R10 normal";
          else tag = "R11 low";
          for (int w = 0; w <= 4; w++) setWs(w, tag);
        end
      end
    end

    // R13: reads proceed with the flag set
    voltMode = 2'd2; freqMhz = 8'd200;
    setWs(0, "R13 flag set");
    readWait(40, "R13 read under flag");
    setWs(4, "R13 flag set");
    readWait(41, "R13 read under flag");
    voltMode = 2'd0; freqMhz = 8'd100;
    readWait(42, "R13 read low mode");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule